// File: doc/BRIEF.md
# Bit-Test Branch Execution Unit

This unit carries out the conditional-branch group of a small 8-bit microcontroller core once the opcode has been decoded. It supports four operations. Two test one bit of an operand and branch when the bit is 1, or when it is 0. A third branches when the bit is 1 and, in that case only, writes the operand back with the bit cleared. The fourth decrements a byte, always stores the result, and branches when the result is not zero. The decoder supplies the operation, the operand class, the bit index, the instruction length, a signed 8-bit displacement, the current program counter, the operand byte, a flag saying whether the operand lives in fast internal RAM, and read and write wait counts.

A one-cycle start strobe samples all of these inputs. The unit then counts off the execution time that applies to that form, which depends on the operation, the operand class, the memory region and any wait states. When the count has elapsed it raises done for one cycle. In that same cycle it presents the next program counter and, if the form writes back, a write strobe with the byte to store. Fetch, opcode decoding and the memory system sit outside the unit.

Top module: `bitbr_exec`

## Requirements
- R1: The next PC is pc + len when the branch is not taken. When the branch is taken it is pc + len + the sign-extended 8-bit displacement. Both results wrap modulo 2^16.
- R2: Operation code 0 branches when operand bit [bit_i] is 1. Operation code 1 branches when that bit is 0. Neither code ever writes back.
- R3: Operation code 2 branches only when the selected bit is 1, and in that case writes back the operand with that bit forced to 0. This also applies to the flag-word class, whose write-back carries the new zero, half-carry and carry flags. When the bit is 0 nothing is written.
- R4: Operation code 3 always writes back operand - 1 modulo 256, and branches only when that result is nonzero.
- R5: Operand class codes are: 0 accumulator, 1 short direct RAM, 2 special register, 3 flag word, 4 pointer-indirect, 5 working register. Bit-test latency for codes 0 and 1: the accumulator takes 8 clocks. Short RAM takes 8 fast / 9 slow clocks for code 0 and 10 fast / 11 slow clocks for code 1. Special register takes 11 clocks. Flag word takes 9 clocks for code 0 and 11 clocks for code 1. Pointer-indirect takes 10 clocks fast, or 11 + rd_wait clocks slow.
- R6: Latency for test-and-clear: accumulator 8 clocks, short RAM 10 fast / 12 slow, special register 12, pointer-indirect 10 fast / 12 slow. Latency for decrement: working register 6 clocks, short RAM 8 fast / 10 slow.
- R7: Flag-word test-and-clear takes 12 + rd_wait + wr_wait clocks. For every form not named with a wait term, the wait counts have no effect. For the accumulator, special register, flag word and working register classes, fast_ram_i has no effect.
- R8: done_o is high for exactly one cycle, N rising edges after the edge that samples start_i, where N is the latency. wb_en_o is high only in a done cycle.
- R9: A start_i that arrives while busy_o is high is ignored. The running operation's results and timing are unchanged.
- R10: An unsupported pairing is treated as a not-taken branch. The unsupported pairings are decrement with classes 0, 2, 3 or 4; a bit operation with class 5; and class codes 6 or 7. Such a pairing completes in 2 clocks, does not write back, and gives next PC = pc + len.
- R11: After reset, busy_o, done_o and wb_en_o are low, and next_pc_o and wb_data_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe; samples all operand inputs |
| op_i | input | 2 | Operation code (R2 to R4) |
| cls_i | input | 3 | Operand class code (R5) |
| bit_i | input | 3 | Bit index within the operand |
| len_i | input | 3 | Instruction length in bytes (2 to 4) |
| disp_i | input | 8 | Signed branch displacement |
| pc_i | input | 16 | Address of the current instruction |
| opnd_i | input | 8 | Operand byte |
| fast_ram_i | input | 1 | Operand is in fast internal RAM |
| rd_wait_i | input | 4 | Read wait cycles |
| wr_wait_i | input | 4 | Write wait cycles |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| next_pc_o | output | 16 | Next program counter, held until the next start |
| wb_data_o | output | 8 | Byte to write back |
| wb_en_o | output | 1 | Write-back strobe, valid with done_o |

## Verification
Some properties are checked by assertions on every cycle. done never lasts two cycles, the counter is never zero while busy, and a start accepted while idle always gives a busy cycle without done. The next PC does not move while busy. A write strobe appears only together with done. A test-and-clear write-back always has the selected bit at 0, and a legal decrement always writes. Other behaviour only the bench's scenarios can show. These are the exact latency of each form and region, including the wait-count additions. They also include the branch conditions for both bit polarities, displacement sign handling and wrap at the top of the address space, the decrement results at 1 and 0, and the fact that a start during a long operation changes nothing.

// File: rtl/bitbr_pkg.sv
package bitbr_pkg;

  typedef enum logic [1:0] {
    OP_BSET  = 2'd0,
    OP_BCLR  = 2'd1,
    OP_BTCLR = 2'd2,
    OP_DEC   = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    CL_ACC   = 3'd0,
    CL_SADDR = 3'd1,
    CL_SFR   = 3'd2,
    CL_FLAGS = 3'd3,
    CL_PTR   = 3'd4,
    CL_REG   = 3'd5
  } cls_e;

  function automatic logic pair_legal(input op_e op, input logic [2:0] cls);
    logic ok;
    case (cls)
      CL_ACC, CL_SFR, CL_FLAGS, CL_PTR: ok = (op != OP_DEC);
      CL_SADDR:                         ok = 1'b1;
      CL_REG:                           ok = (op == OP_DEC);
      default:                          ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/bitbr_rst_sync.sv
module bitbr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/bitbr_eval.sv
module bitbr_eval
  import bitbr_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DATA_W = 8,
  parameter int DISP_W = 8,
  parameter int LEN_W  = 3,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  op_e               op_i,
  input  logic [2:0]        cls_i,
  input  logic [IDX_W-1:0]  bit_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic              legal_o,
  output logic [PC_W-1:0]   next_pc_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic              wb_en_o
);
  logic              sel_bit;
  logic              taken;
  logic [DATA_W-1:0] dec_val;
  logic [DATA_W-1:0] clr_mask;
  logic [PC_W-1:0]   fall_pc;
  logic [PC_W-1:0]   disp_ext;

  assign legal_o  = pair_legal(op_i, cls_i);
  assign sel_bit  = opnd_i[bit_i];
  assign dec_val  = opnd_i - DATA_W'(1);
  assign clr_mask = ~(DATA_W'(1) << bit_i);
  assign fall_pc  = pc_i + PC_W'(len_i);
  assign disp_ext = {{(PC_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};

  always_comb begin
    taken     = 1'b0;
    wb_en_o   = 1'b0;
    wb_data_o = '0;
    if (legal_o) begin
      unique case (op_i)
        OP_BSET: taken = sel_bit;
        OP_BCLR: taken = ~sel_bit;
        OP_BTCLR: begin
          taken     = sel_bit;
          wb_en_o   = sel_bit;
          wb_data_o = sel_bit ? (opnd_i & clr_mask) : '0;
        end
        OP_DEC: begin
          taken     = (dec_val != '0);
          wb_en_o   = 1'b1;
          wb_data_o = dec_val;
        end
        default: taken = 1'b0;
      endcase
    end
  end

  assign next_pc_o = taken ? (fall_pc + disp_ext) : fall_pc;
endmodule

// File: rtl/bitbr_cycles.sv
module bitbr_cycles
  import bitbr_pkg::*;
#(
  parameter int WAIT_W = 4,
  parameter int CNT_W  = 6
) (
  input  op_e               op_i,
  input  logic [2:0]        cls_i,
  input  logic              legal_i,
  input  logic              fast_i,
  input  logic [WAIT_W-1:0] rd_wait_i,
  input  logic [WAIT_W-1:0] wr_wait_i,
  output logic [CNT_W-1:0]  cycles_o
);
  logic [CNT_W-1:0] base;
  logic             add_rd;
  logic             add_wr;

  always_comb begin
    base   = CNT_W'(2);
    add_rd = 1'b0;
    add_wr = 1'b0;
    if (legal_i) begin
      case (cls_i)
        CL_ACC: base = CNT_W'(8);
        CL_SADDR: begin
          unique case (op_i)
            OP_BSET:  base = fast_i ? CNT_W'(8)  : CNT_W'(9);
            OP_BCLR:  base = fast_i ? CNT_W'(10) : CNT_W'(11);
            OP_BTCLR: base = fast_i ? CNT_W'(10) : CNT_W'(12);
            default:  base = fast_i ? CNT_W'(8)  : CNT_W'(10);
          endcase
        end
        CL_SFR: base = (op_i == OP_BTCLR) ? CNT_W'(12) : CNT_W'(11);
        CL_FLAGS: begin
          unique case (op_i)
            OP_BSET: base = CNT_W'(9);
            OP_BCLR: base = CNT_W'(11);
            default: begin
              base   = CNT_W'(12);
              add_rd = 1'b1;
              add_wr = 1'b1;
            end
          endcase
        end
        CL_PTR: begin
          if (op_i == OP_BTCLR) begin
            base = fast_i ? CNT_W'(10) : CNT_W'(12);
          end else begin
            base   = fast_i ? CNT_W'(10) : CNT_W'(11);
            add_rd = ~fast_i;
          end
        end
        CL_REG:  base = CNT_W'(6);
        default: base = CNT_W'(2);
      endcase
    end
  end

  assign cycles_o = base
                  + (add_rd ? CNT_W'(rd_wait_i) : '0)
                  + (add_wr ? CNT_W'(wr_wait_i) : '0);
endmodule

// File: rtl/bitbr_seq.sv
module bitbr_seq #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cycles_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             done_o
);
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign accept_o = start_i & ~busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    cnt_en = 1'b0;
    if (accept_o) begin
      busy_d = 1'b1;
      cnt_d  = cycles_i;
      cnt_en = 1'b1;
    end else if (busy_q) begin
      cnt_en = 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R8
  cnt_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q != '0));

  // R9
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> (busy_q && !done_q));
endmodule

// File: rtl/bitbr_exec.sv
module bitbr_exec
  import bitbr_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DATA_W = 8,
  parameter int DISP_W = 8,
  parameter int LEN_W  = 3,
  parameter int WAIT_W = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [1:0]                 op_i,
  input  logic [2:0]                 cls_i,
  input  logic [$clog2(DATA_W)-1:0]  bit_i,
  input  logic [LEN_W-1:0]           len_i,
  input  logic [DISP_W-1:0]          disp_i,
  input  logic [PC_W-1:0]            pc_i,
  input  logic [DATA_W-1:0]          opnd_i,
  input  logic                       fast_ram_i,
  input  logic [WAIT_W-1:0]          rd_wait_i,
  input  logic [WAIT_W-1:0]          wr_wait_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [PC_W-1:0]            next_pc_o,
  output logic [DATA_W-1:0]          wb_data_o,
  output logic                       wb_en_o
);
  localparam int IDX_W   = $clog2(DATA_W);
  localparam int MAX_CYC = 12 + 2 * ((1 << WAIT_W) - 1);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic              rst_sync_n;
  op_e               op;
  logic              legal;
  logic [PC_W-1:0]   eval_pc;
  logic [DATA_W-1:0] eval_data;
  logic              eval_wb;
  logic [CNT_W-1:0]  cycles;
  logic              accept;

  logic [PC_W-1:0]   next_pc_q;
  logic [DATA_W-1:0] wb_data_q;
  logic              wb_pend_q;
  op_e               op_q;
  logic [IDX_W-1:0]  bit_q;
  logic              legal_q;

  assign op = op_e'(op_i);

  bitbr_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  bitbr_eval #(
    .PC_W(PC_W), .DATA_W(DATA_W), .DISP_W(DISP_W), .LEN_W(LEN_W)
  ) u_eval (
    .op_i      (op),
    .cls_i     (cls_i),
    .bit_i     (bit_i),
    .len_i     (len_i),
    .disp_i    (disp_i),
    .pc_i      (pc_i),
    .opnd_i    (opnd_i),
    .legal_o   (legal),
    .next_pc_o (eval_pc),
    .wb_data_o (eval_data),
    .wb_en_o   (eval_wb)
  );

  bitbr_cycles #(.WAIT_W(WAIT_W), .CNT_W(CNT_W)) u_cycles (
    .op_i      (op),
    .cls_i     (cls_i),
    .legal_i   (legal),
    .fast_i    (fast_ram_i),
    .rd_wait_i (rd_wait_i),
    .wr_wait_i (wr_wait_i),
    .cycles_o  (cycles)
  );

  bitbr_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .start_i  (start_i),
    .cycles_i (cycles),
    .accept_o (accept),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      next_pc_q <= '0;
      wb_data_q <= '0;
      wb_pend_q <= 1'b0;
      op_q      <= OP_BSET;
      bit_q     <= '0;
      legal_q   <= 1'b0;
    end else if (accept) begin
      next_pc_q <= eval_pc;
      wb_data_q <= eval_data;
      wb_pend_q <= eval_wb;
      op_q      <= op;
      bit_q     <= bit_i;
      legal_q   <= legal;
    end
  end

  assign next_pc_o = next_pc_q;
  assign wb_data_o = wb_data_q;
  assign wb_en_o   = done_o & wb_pend_q;

  // R8
  wb_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    wb_en_o |-> done_o);

  // R3
  btclr_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (wb_en_o && op_q == OP_BTCLR) |-> (wb_data_o[bit_q] == 1'b0));

  // R4
  dec_writes_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (done_o && legal_q && op_q == OP_DEC) |-> wb_en_o);

  // R9
  pc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    busy_o |=> $stable(next_pc_o));
endmodule

// File: tb/bitbr_exec_bench.sv
module bitbr_exec_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = '0;
  logic [2:0]  cls = '0;
  logic [2:0]  bidx = '0;
  logic [2:0]  len = '0;
  logic [7:0]  disp = '0;
  logic [15:0] pc = '0;
  logic [7:0]  opnd = '0;
  logic        fast = 1'b0;
  logic [3:0]  rw = '0;
  logic [3:0]  ww = '0;
  logic        busy, done, wb_en;
  logic [15:0] next_pc;
  logic [7:0]  wb_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int npush = 0;
  int npop = 0;
  bit live = 1'b0;

  typedef struct {
    int    pc;
    bit    wb;
    int    data;
    int    lat;
    int    issue;
    string tag;
  } exp_t;

  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bitbr_exec u_bitbr_exec (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .cls_i(cls),
    .bit_i(bidx), .len_i(len), .disp_i(disp), .pc_i(pc), .opnd_i(opnd),
    .fast_ram_i(fast), .rd_wait_i(rw), .wr_wait_i(ww), .busy_o(busy),
    .done_o(done), .next_pc_o(next_pc), .wb_data_o(wb_data), .wb_en_o(wb_en)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit pair_ok(input int o, input int c);
    if (c == 1) return 1'b1;
    if (c == 5) return o == 3;
    if (c <= 4) return o != 3;
    return 1'b0;
  endfunction

  function automatic int exp_lat(input int o, input int c, input bit f,
                                 input int r, input int w);
    if (!pair_ok(o, c)) return 2;
    case (c)
      0: return 8;
      1: case (o) 0: return f ? 8 : 9; 1: return f ? 10 : 11;
                  2: return f ? 10 : 12; default: return f ? 8 : 10; endcase
      2: return (o == 2) ? 12 : 11;
      3: case (o) 0: return 9; 1: return 11; default: return 12 + r + w; endcase
      4: if (o == 2) return f ? 10 : 12; else return f ? 10 : 11 + r;
      default: return 6;
    endcase
  endfunction

  task automatic launch(input int o, input int c, input int b, input int l,
                        input int d, input int p, input int v, input bit f,
                        input int r, input int w, input string tag);
    exp_t e;
    int bitv, taken, sd;
    bit ok;
    ok = pair_ok(o, c);
    bitv = (v >> b) & 1;
    taken = 0; e.wb = 1'b0; e.data = 0;
    if (ok) begin
      case (o)
        0: taken = bitv;
        1: taken = !bitv;
        2: begin taken = bitv; e.wb = bitv[0]; e.data = v & ~(1 << b) & 255; end
        default: begin e.data = (v - 1) & 255; e.wb = 1'b1; taken = (e.data != 0); end
      endcase
    end
    sd = (d >= 128) ? d - 256 : d;
    e.pc = taken ? ((p + l + sd) & 16'hFFFF) : ((p + l) & 16'hFFFF);
    e.lat = exp_lat(o, c, f, r, w);
    e.tag = tag;
    @(negedge clk);
    op = 2'(o); cls = 3'(c); bidx = 3'(b); len = 3'(l); disp = 8'(d);
    pc = 16'(p); opnd = 8'(v); fast = f; rw = 4'(r); ww = 4'(w);
    start = 1'b1;
    e.issue = cyc;
    q.push_back(e);
    npush++;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_all();
    while (npop < npush) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run(input int o, input int c, input int b, input int l,
                     input int d, input int p, input int v, input bit f,
                     input int r, input int w, input string tag);
    launch(o, c, b, l, d, p, v, f, r, w, tag);
    wait_all();
  endtask

  always @(negedge clk) begin
    if (live) begin
      if (wb_en && !done) check(1'b0, "R8", "wb_en outside done", 1, 0);
      if (done) begin
        if (q.size() == 0) begin
          check(1'b0, "R9", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          npop++;
          check(int'(next_pc) == e.pc, e.tag, "next_pc", int'(next_pc), e.pc);
          check(wb_en == e.wb, e.tag, "wb_en", int'(wb_en), int'(e.wb));
          if (e.wb) check(int'(wb_data) == e.data, e.tag, "wb_data", int'(wb_data), e.data);
          check(cyc - e.issue - 1 == e.lat, {e.tag, " R8"}, "latency",
                cyc - e.issue - 1, e.lat);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", npop, npush);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!busy && !done && !wb_en, "R11", "control outputs", int'({busy, done, wb_en}), 0);
    check(next_pc == 16'h0 && wb_data == 8'h0, "R11", "data outputs", int'(next_pc), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !done, "R11", "idle after release", int'({busy, done}), 0);
    live = 1'b1;

    // R2 R5 accumulator set-test, taken and not taken; fast flag irrelevant (R7)
    run(0, 0, 3, 3, 5, 16'h1000, 8'h08, 1'b0, 9, 9, "R1/R2/R5/R7");
    run(0, 0, 3, 3, 5, 16'h1000, 8'hF7, 1'b1, 0, 0, "R1/R2");
    // R2 R1 clear-test on short RAM with negative displacement
    run(1, 1, 0, 4, 8'h80, 16'h2000, 8'hFE, 1'b1, 0, 0, "R1/R2/R5");
    run(1, 1, 0, 4, 8'h80, 16'h2000, 8'h01, 1'b0, 0, 0, "R2/R5");
    run(0, 1, 6, 3, 2, 16'h0300, 8'h40, 1'b0, 0, 0, "R5");
    run(0, 1, 6, 3, 2, 16'h0300, 8'h40, 1'b1, 0, 0, "R5");
    // R5 R7 pointer-indirect with read waits
    run(0, 4, 2, 3, 16, 16'h4000, 8'h04, 1'b0, 3, 7, "R5/R7");
    run(1, 4, 2, 3, 16, 16'h4000, 8'h04, 1'b1, 3, 7, "R5/R7");
    run(0, 2, 5, 4, 1, 16'h0100, 8'h20, 1'b1, 4, 4, "R5/R7");
    run(1, 2, 5, 4, 1, 16'h0100, 8'h20, 1'b0, 0, 0, "R5");
    run(0, 3, 1, 3, 1, 16'h0100, 8'h02, 1'b0, 6, 6, "R5/R7");
    run(1, 3, 1, 4, 1, 16'h0100, 8'h02, 1'b0, 0, 0, "R5");
    // R3 R6 test-and-clear
    run(2, 2, 7, 4, 8'hF0, 16'h0500, 8'h85, 1'b1, 0, 0, "R3/R6");
    run(2, 1, 4, 4, 3, 16'h0500, 8'hEF, 1'b1, 0, 0, "R3/R6");
    run(2, 1, 4, 4, 3, 16'h0500, 8'h10, 1'b0, 0, 0, "R3/R6");
    run(2, 3, 6, 4, 8, 16'h0600, 8'h41, 1'b0, 2, 3, "R3/R7");
    run(2, 4, 0, 3, 8, 16'h0600, 8'h01, 1'b0, 5, 5, "R3/R6/R7");
    run(2, 0, 2, 3, 8, 16'h0600, 8'hFF, 1'b0, 0, 0, "R3/R6");
    // R4 R6 decrement, zero result, underflow and wrap of the PC (R1)
    run(3, 5, 0, 2, 8'h10, 16'hFFFF, 8'h01, 1'b0, 0, 0, "R1/R4/R6");
    run(3, 5, 0, 2, 8'h7F, 16'hFFF0, 8'h00, 1'b0, 0, 0, "R1/R4/R6");
    run(3, 1, 0, 3, 8'hFC, 16'h0800, 8'h10, 1'b0, 0, 0, "R4/R6");
    run(3, 1, 0, 3, 8'hFC, 16'h0800, 8'h10, 1'b1, 0, 0, "R4/R6");
    // R10 unsupported pairings
    run(3, 0, 0, 3, 9, 16'h0900, 8'h05, 1'b1, 0, 0, "R10");
    run(0, 5, 0, 2, 9, 16'h0900, 8'hFF, 1'b1, 0, 0, "R10");
    run(2, 7, 0, 3, 9, 16'h0900, 8'hFF, 1'b1, 0, 0, "R10");
    // R9 start while busy is ignored
    launch(2, 3, 0, 4, 4, 16'h0A00, 8'h81, 1'b0, 15, 15, "R9/R3/R7");
    repeat (3) @(negedge clk);
    op = 2'd3; cls = 3'd5; pc = 16'h1234; opnd = 8'h02; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_all();
    repeat (10) @(negedge clk);
    check(npop == npush && q.size() == 0, "R9", "completions", npop, npush);
    check(!busy, "R9", "idle after ignored start", int'(busy), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule